// File: doc/BRIEF.md
# Timestamp Capture Queue

The block keeps the PTP timestamp of every timing event frame that the frame parser finds, in either the receive or the transmit direction. For each frame it also keeps the identity fields of that frame. When the parser raises a capture strobe in the line clock domain, the block samples the running PTP time and the frame identity in that same cycle. It packs them into one 128-bit entry and writes the entry into a dual-clock FIFO.

Software in the CPU clock domain drains the FIFO through a request/acknowledge port. Each request selects one of the four 32-bit words of the entry at the head of the queue, and the data returns together with the acknowledge. The entry leaves the queue only when its last word is read. A fill count and an empty flag show how many entries are waiting.

When the FIFO is full, a new capture is dropped and a sticky overflow flag is set. The flag stays set until software clears it. One instance serves one direction, so the transmit and receive queues are separate instances with their own address ranges.

Top module: `ts_capture_queue`

## Requirements
- R1: An entry holds, from bit 127 down to bit 0: 16 zero bits, the 48-bit seconds, the 32-bit nanoseconds, the 4-bit message type, the 12-bit checksum field and the 16-bit sequence id. The value of rd_sel picks the word: 3 returns bits 127:96, 2 returns bits 95:64, 1 returns bits 63:32 and 0 returns bits 31:0.
- R2: The time and identity stored in an entry are the values present on the inputs in the lclk cycle where cap_stb is high.
- R3: The queue holds 16 entries. A capture that arrives while 16 entries are stored is dropped.
- R4: A dropped capture sets ovf_flag. The flag stays set until a pulse on ovf_clr, and after that pulse it reads 0.
- R5: A request (rd_req high at a cclk edge) gives rd_ack high at the next cclk edge, with rd_data holding the selected word of the head entry. rd_ack is low in all other cycles.
- R6: Reading word 3, 2 or 1 leaves the queue unchanged. A read of word 0 from a non-empty queue removes the head entry.
- R7: Entries are read out in the order they were captured.
- R8: A request to an empty queue returns rd_data = 0 and removes nothing.
- R9: rd_count never exceeds the number of entries captured minus the number removed. Once captures have stopped for a few cycles, rd_count equals that number and rd_empty is high exactly when it is 0.
- R10: After reset the queue is empty, rd_count is 0, and both ovf_flag and rd_ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Line clock |
| lrst_n | input | 1 | Line domain reset, active low |
| cap_stb | input | 1 | Capture strobe for one event frame |
| cap_msg_type | input | 4 | Message type of the frame |
| cap_csum | input | 12 | Checksum field of the frame |
| cap_seq_id | input | 16 | Sequence id of the frame |
| ptp_sec | input | 48 | Current PTP seconds |
| ptp_ns | input | 32 | Current PTP nanoseconds |
| cclk | input | 1 | CPU clock |
| crst_n | input | 1 | CPU domain reset, active low |
| rd_req | input | 1 | Read request |
| rd_sel | input | 2 | Word select, 3 down to 0 |
| rd_ack | output | 1 | Read acknowledge |
| rd_data | output | 32 | Selected word of the head entry |
| rd_count | output | 5 | Entries waiting |
| rd_empty | output | 1 | Queue empty |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The PTP time inputs change on every line clock. A design that sampled the time one cycle late, or that only sampled it once parsing had finished, would therefore store wrong values, and the word-by-word comparison would report them. The bench fills the queue with a back-to-back burst of seventeen captures. A design with an off-by-one full test would either keep the seventeenth entry or lose the sixteenth, and the overflow flag would be wrong. Reads of the upper words without the final word check that a premature pop would shift the later data. Reads from an empty queue check that a pop on empty would corrupt the pointers and make rd_count wrap.

// File: rtl/ts_capture_queue.sv
`timescale 1ns/1ps
module ts_capture_queue #(
  parameter int AW = 4
) (
  input  logic          lclk,
  input  logic          lrst_n,
  input  logic          cap_stb,
  input  logic [3:0]    cap_msg_type,
  input  logic [11:0]   cap_csum,
  input  logic [15:0]   cap_seq_id,
  input  logic [47:0]   ptp_sec,
  input  logic [31:0]   ptp_ns,
  input  logic          cclk,
  input  logic          crst_n,
  input  logic          rd_req,
  input  logic [1:0]    rd_sel,
  output logic          rd_ack,
  output logic [31:0]   rd_data,
  output logic [AW:0]   rd_count,
  output logic          rd_empty,
  input  logic          ovf_clr,
  output logic          ovf_flag
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [127:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic          ovf_lvl, clr_tgl, ct_s1, ct_s2, ct_s3, ov_s1, ov_s2;

  // line domain: pack, push, full test
  wire [127:0]  entry   = {16'h0, ptp_sec, ptp_ns, cap_msg_type, cap_csum, cap_seq_id};
  wire [PW-1:0] wr_fill = wbin - to_bin(rg_s2);
  wire          full    = wr_fill == PW'(DEPTH);
  wire          push    = cap_stb && !full;
  wire          clr_evt = ct_s2 ^ ct_s3;

  always_ff @(posedge lclk) if (push) mem[wbin[AW-1:0]] <= entry;

  always_ff @(posedge lclk or negedge lrst_n)
    if (!lrst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      ct_s1 <= 1'b0; ct_s2 <= 1'b0; ct_s3 <= 1'b0; ovf_lvl <= 1'b0;
    end else begin
      rg_s1 <= rgray; rg_s2 <= rg_s1;
      ct_s1 <= clr_tgl; ct_s2 <= ct_s1; ct_s3 <= ct_s2;
      if (push) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
      if (cap_stb && full) ovf_lvl <= 1'b1;
      else if (clr_evt)    ovf_lvl <= 1'b0;
    end

  // cpu domain: status, handshake, pop
  wire [127:0] head = mem[rbin[AW-1:0]];
  assign rd_count = to_bin(wg_s2) - rbin;
  assign rd_empty = rd_count == '0;
  assign ovf_flag = ov_s2;
  wire pop = rd_req && rd_sel == 2'd0 && !rd_empty;

  always_ff @(posedge cclk or negedge crst_n)
    if (!crst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      ov_s1 <= 1'b0; ov_s2 <= 1'b0; clr_tgl <= 1'b0;
      rd_ack <= 1'b0; rd_data <= '0;
    end else begin
      wg_s1 <= wgray; wg_s2 <= wg_s1;
      ov_s1 <= ovf_lvl; ov_s2 <= ov_s1;
      if (ovf_clr) clr_tgl <= ~clr_tgl;
      rd_ack <= rd_req;
      if (rd_req) rd_data <= rd_empty ? 32'h0 : head[{rd_sel, 5'b0} +: 32];
      if (pop) begin
        rbin  <= rbin + 1'b1;
        rgray <= to_gray(rbin + 1'b1);
      end
    end
endmodule

// File: rtl/ts_capture_queue_chk.sv
`timescale 1ns/1ps
module ts_capture_queue_chk #(
  parameter int AW = 4
) (
  input logic          lclk,
  input logic          lrst_n,
  input logic          cclk,
  input logic          crst_n,
  input logic          rd_req,
  input logic [1:0]    rd_sel,
  input logic          rd_ack,
  input logic [31:0]   rd_data,
  input logic          rd_empty,
  input logic [AW:0]   rd_count,
  input logic [AW:0]   wr_fill
);
  localparam int DEPTH = 1 << AW;

  a_r5_ack_after_req: assert property (@(posedge cclk) disable iff (!crst_n)
    rd_req |=> rd_ack);
  a_r5_ack_only_on_req: assert property (@(posedge cclk) disable iff (!crst_n)
    rd_ack |-> $past(rd_req));
  a_r8_empty_reads_zero: assert property (@(posedge cclk) disable iff (!crst_n)
    (rd_req && rd_empty) |=> rd_data == 32'h0);
  a_r6_no_drop_without_pop: assert property (@(posedge cclk) disable iff (!crst_n)
    !(rd_req && rd_sel == 2'd0) |=> rd_count >= $past(rd_count));
  a_r9_count_bounded: assert property (@(posedge cclk) disable iff (!crst_n)
    rd_count <= (AW+1)'(DEPTH));
  a_r3_fill_bounded: assert property (@(posedge lclk) disable iff (!lrst_n)
    wr_fill <= (AW+1)'(DEPTH));
endmodule

bind ts_capture_queue ts_capture_queue_chk #(.AW(AW)) chk_i (
  .lclk(lclk), .lrst_n(lrst_n), .cclk(cclk), .crst_n(crst_n),
  .rd_req(rd_req), .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_data(rd_data),
  .rd_empty(rd_empty), .rd_count(rd_count), .wr_fill(wr_fill)
);

// File: tb/ts_capture_queue_tb_top.sv
`timescale 1ns/1ps
module ts_capture_queue_tb_top;
  logic lclk = 1'b0, cclk = 1'b0, lrst_n = 1'b0, crst_n = 1'b0;
  logic cap_stb = 1'b0;
  logic [3:0] cap_msg_type = '0;
  logic [11:0] cap_csum = '0;
  logic [15:0] cap_seq_id = '0;
  logic [47:0] ptp_sec = 48'h0000_1234_5678;
  logic [31:0] ptp_ns = 32'h0100_0000;
  logic rd_req = 1'b0, ovf_clr = 1'b0;
  logic [1:0] rd_sel = '0;
  logic rd_ack, rd_empty, ovf_flag;
  logic [31:0] rd_data;
  logic [4:0] rd_count;

  ts_capture_queue dut_i (.*);

  always #10 lclk = ~lclk;
  always #15 cclk = ~cclk;

  int checks = 0, fails = 0, quiet = 0;
  logic [127:0] q[$];
  bit mflag = 0, req_seen = 0, done = 0;
  logic [31:0] exp_word;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // time base moves every line cycle (R2)
  always @(posedge lclk) begin
    #1;
    ptp_ns  = ptp_ns + 32'd13;
    ptp_sec = ptp_sec + 48'd1;
  end

  // line-side model
  always @(posedge lclk) begin
    if (!lrst_n) quiet = 0;
    else if (cap_stb) begin
      quiet = 0;
      if (q.size() < 16) q.push_back({16'h0, ptp_sec, ptp_ns, cap_msg_type, cap_csum, cap_seq_id});
      else mflag = 1;
    end else quiet++;
  end

  // cpu-side model: record the request at the edge it is sampled
  always @(posedge cclk) begin
    req_seen = crst_n && rd_req;
    if (req_seen) begin
      if (q.size() == 0) exp_word = 32'h0;
      else begin
        exp_word = q[0][rd_sel*32 +: 32];
        if (rd_sel == 2'd0) void'(q.pop_front());
      end
    end
  end

  // compared on every cpu clock
  always @(negedge cclk) if (crst_n && lrst_n) begin
    chk(rd_ack == req_seen, "R5 ack", rd_ack, req_seen);
    if (req_seen) chk(rd_data == exp_word, "R1/R7/R8 data", rd_data, exp_word);
    chk(rd_count <= q.size(), "R9 count bound", rd_count, q.size());
    if (quiet >= 6) begin
      chk(rd_count == q.size(), "R9 count", rd_count, q.size());
      chk(rd_empty == (q.size() == 0), "R9 empty", rd_empty, q.size() == 0);
    end
  end

  task automatic capture(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(posedge lclk); #2;
      cap_stb = 1'b1;
      cap_msg_type = 4'(base + i);
      cap_csum = 12'hA50 ^ 12'(i * 7);
      cap_seq_id = 16'(base * 100 + i);
    end
    @(posedge lclk); #2;
    cap_stb = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel);
    @(posedge cclk); #2;
    rd_req = 1'b1; rd_sel = sel;
    @(posedge cclk); #2;
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge cclk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge cclk);
    #2; lrst_n = 1'b1; crst_n = 1'b1;
    @(negedge cclk);
    // R10 reset state
    chk(rd_empty == 1'b1, "R10 empty", rd_empty, 1);
    chk(rd_count == 0, "R10 count", rd_count, 0);
    chk(ovf_flag == 1'b0, "R10 ovf", ovf_flag, 0);
    chk(rd_ack == 1'b0, "R10 ack", rd_ack, 0);

    // R8 read empty queue
    rd(2'd0); rd(2'd2); idle(3);
    chk(rd_count == 0, "R8 no pop on empty", rd_count, 0);

    // R1 R2 R7 single entries, all words
    capture(3, 1); idle(8);
    chk(rd_count == 3, "R9 three queued", rd_count, 3);
    // R6 upper words do not pop
    rd(2'd3); rd(2'd2); rd(2'd1); idle(2);
    chk(rd_count == 3, "R6 no pop on words 3..1", rd_count, 3);
    rd(2'd3); rd(2'd0); idle(2);
    chk(rd_count == 2, "R6 pop on word 0", rd_count, 2);
    for (int i = 0; i < 2; i++) begin
      rd(2'd3); rd(2'd2); rd(2'd1); rd(2'd0);
    end
    idle(3);
    chk(rd_empty == 1'b1, "R7 drained", rd_empty, 1);

    // R3 R4 overflow burst of 17
    capture(17, 5); idle(10);
    chk(rd_count == 16, "R3 holds 16", rd_count, 16);
    chk(ovf_flag == 1'b1 && mflag, "R4 ovf set", ovf_flag, 1);
    rd(2'd0); rd(2'd0); idle(10);
    chk(ovf_flag == 1'b1, "R4 sticky", ovf_flag, 1);
    @(posedge cclk); #2; ovf_clr = 1'b1;
    @(posedge cclk); #2; ovf_clr = 1'b0;
    mflag = 0;
    idle(10);
    chk(ovf_flag == 1'b0, "R4 cleared", ovf_flag, 0);
    // R7 order of the remaining burst
    for (int i = 0; i < 14; i++) begin
      rd(2'd1); rd(2'd0);
    end
    idle(4);
    chk(rd_count == 0, "R3 burst drained", rd_count, 0);
    rd(2'd0); idle(3);
    chk(rd_count == 0 && ovf_flag == 1'b0, "R8 empty after drain", rd_count, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule